// File: doc/BRIEF.md
# Audio Sample FIFO With Status

This block buffers 24-bit audio samples for one direction of a serial audio port. A register bus reaches it through three addresses: control, status and data. In playback form the bus writes samples into the data address and the serializer takes one sample per channel slot with a strobe. In capture form the serializer delivers a sample per strobe and the bus reads samples back from the data address. The parameter `IS_PLAY` picks the direction.

Storage is fixed at 256 words. The usable depth in frames follows from the channel count, so more channels leave fewer frames. The status register reports the fill level in whole frames. It also holds two sticky error flags, one for a sample lost on a full FIFO and one for a pop from an empty FIFO. A level interrupt tells software when the FIFO needs service: at half depth or less for playback, at half depth or more for capture. A self-clearing control bit empties the FIFO in one cycle.

A small state machine tracks the fill condition. Its states are `FS_EMPTY`, `FS_PART`, `FS_FULL` and `FS_BADCFG`. The next state is computed every cycle from the word count after that cycle's transfers:
- An illegal channel count leads to `FS_BADCFG` from any state.
- Otherwise a flush or a count of zero leads to `FS_EMPTY`.
- A count at or above the word limit leads to `FS_FULL`.
- Anything else leads to `FS_PART`.

In `FS_EMPTY` only pushes are accepted. `FS_PART` accepts both pushes and pops. `FS_FULL` accepts only pops. `FS_BADCFG` accepts neither.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset the FIFO is empty. Status and control both read 0, and `irq_half` is low.
- R2: The frame capacity depends on the channel count. One channel gives 256 frames, two give 128, three or four give 64, and five to eight give 32. The FIFO accepts exactly capacity × channels words.
- R3: Status bits [16:8] hold the fill level as whole frames, computed as stored words divided by the channel count and rounded down.
- R4: Samples leave the FIFO in the order they entered. Only bits [23:0] of a bus write are kept, and bits [31:24] of a data read are 0. A 16-bit sample placed at [23:8] comes back at [23:8]. `ser_dout` (playback) and a data read (capture) show the oldest sample in the cycle of an accepted pop, and 0 otherwise.
- R5: A push into a full FIFO is dropped and sets status bit 4 (overflow). This bit stays set until it is cleared.
- R6: A pop from an empty FIFO returns 0 and sets status bit 0 (underflow). This bit stays set until it is cleared.
- R7: Writing the status address clears each error flag whose bit is written as 1. A 0 leaves the flag as it is. A new error in the same cycle wins over the clear.
- R8: Writing 1 to control bit 0 empties the FIFO in that cycle, and the bit always reads 0. A serial transfer in the same cycle is discarded and raises no error.
- R9: Control bit 20 enables the level interrupt. In playback `irq_half` is high while the fill level in frames is at most half the capacity. In capture it is high while the level is at least half the capacity. It stays high for as long as the condition and the enable hold.
- R10: A channel count of 0 or above 8 raises `cfg_err`. While it is raised nothing is stored, every push sets overflow, every pop sets underflow, and the level reads 0.
- R11: A push and a pop in the same cycle on a partly filled FIFO are both accepted, and the level is unchanged. On a full FIFO the pop is accepted and the push is dropped with overflow.
- R12: Control reads back bit 20 as last written and 0 in all other bits. Address 0 is control, 1 is status, 2 is data, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_chans | input | 4 | Channels per frame (1 to 8 legal) |
| cfg_err | output | 1 | Channel count is illegal |
| bus_sel | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (pops on the data address in capture) |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational from the address |
| ser_strobe | input | 1 | Serializer slot strobe: pop (playback) or push (capture) |
| ser_din | input | 24 | Sample from the serializer (capture) |
| ser_dout | output | 24 | Sample to the serializer (playback) |
| irq_half | output | 1 | Level interrupt request |

## Verification
The two functions that share a cycle are a push and a pop, because the bus and the serializer drive opposite ends of the FIFO independently. A flush can also land together with a serial strobe. Directed sequences force a simultaneous push and pop both on a partly filled FIFO and on a full one. They also place a flush together with a strobe. Random traffic then mixes bus writes, data reads, strobes and occasional flushes at several channel counts. The bench keeps a reference queue per direction and judges every cycle. It compares the popped sample, the register readback, the level, the sticky flags and the interrupt against what the queue says the rules require.

// File: rtl/asfifo_pkg.sv
package asfifo_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY  = 2'd0,
        FS_PART   = 2'd1,
        FS_FULL   = 2'd2,
        FS_BADCFG = 2'd3
    } fill_state_e;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;

    localparam int CTL_HALF_EN = 20;
    localparam int CTL_FLUSH   = 0;
    localparam int ST_OVF      = 4;
    localparam int ST_UNF      = 0;
    localparam int ST_LVL_LSB  = 8;

endpackage

// File: rtl/asfifo_capmap.sv
module asfifo_capmap #(
    parameter int TOTAL_WORDS = 256,
    parameter int MAX_CH      = 8,
    parameter int CW          = 4,
    parameter int LW          = 9
) (
    input  logic [CW-1:0] chans,
    output logic [LW-1:0] cap_frames,
    output logic [LW-1:0] limit_words,
    output logic          cfg_bad
);
    localparam int SHW = $clog2(MAX_CH) + 1;

    int shamt;

    // capacity = storage >> ceil(log2(channels))
    always_comb begin
        shamt = 0;
        for (int k = 0; k < SHW; k++) begin
            if ((1 << k) < int'(chans)) shamt = k + 1;
        end
        cfg_bad     = (chans == '0) || (int'(chans) > MAX_CH);
        cap_frames  = cfg_bad ? '0 : LW'(TOTAL_WORDS >> shamt);
        limit_words = cfg_bad ? '0 : LW'(int'(cap_frames) * int'(chans));
    end
endmodule

// File: rtl/asfifo_store.sv
module asfifo_store #(
    parameter int DW    = 24,
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int LW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic [LW-1:0] words
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            words <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            words <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            words <= words + LW'(push) - LW'(pop);
        end
    end

    assign head = mem[rp];
endmodule

// File: rtl/asfifo_fsm.sv
module asfifo_fsm
    import asfifo_pkg::*;
#(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_bad,
    input  logic          flush,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [LW-1:0] words,
    input  logic [LW-1:0] limit_words,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          ovf_ev,
    output logic          unf_ev,
    output fill_state_e   state
);
    fill_state_e   state_nxt;
    logic [LW-1:0] words_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        unique case (state)
            FS_EMPTY:  push_ok = push_req;
            FS_PART: begin
                push_ok = push_req;
                pop_ok  = pop_req;
            end
            FS_FULL:   pop_ok = pop_req;
            FS_BADCFG: ;
        endcase
        if (flush || cfg_bad) begin
            push_ok = 1'b0;
            pop_ok  = 1'b0;
        end
        ovf_ev = push_req && !flush && !push_ok;
        unf_ev = pop_req  && !flush && !pop_ok;
    end

    always_comb begin
        words_nxt = words + LW'(push_ok) - LW'(pop_ok);
        if (cfg_bad)                         state_nxt = FS_BADCFG;
        else if (flush || words_nxt == '0)   state_nxt = FS_EMPTY;
        else if (words_nxt >= limit_words)   state_nxt = FS_FULL;
        else                                 state_nxt = FS_PART;
    end
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
    import asfifo_pkg::*;
#(
    parameter bit IS_PLAY     = 1'b1,
    parameter int TOTAL_WORDS = 256,
    parameter int MAX_CH      = 8,
    parameter int DW          = 24,
    parameter int BW          = 32,
    parameter int CW          = $clog2(MAX_CH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_chans,
    output logic          cfg_err,
    input  logic [1:0]    bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          ser_strobe,
    input  logic [DW-1:0] ser_din,
    output logic [DW-1:0] ser_dout,
    output logic          irq_half
);
    localparam int AW = $clog2(TOTAL_WORDS);
    localparam int LW = AW + 1;

    logic          flush, ctrl_wr, stat_wr, data_wr, data_rd;
    logic          push_req, pop_req, push_ok, pop_ok, ovf_ev, unf_ev;
    logic [DW-1:0] push_din, head;
    logic [LW-1:0] words, cap_frames, limit_words, frames, half_lvl;
    logic          cfg_bad, half_hit;
    logic          half_en_q, ovf_q, unf_q;
    fill_state_e   state;
    logic          unused_bits;

    assign ctrl_wr = bus_wr && (bus_sel == RA_CTRL);
    assign stat_wr = bus_wr && (bus_sel == RA_STAT);
    assign data_wr = bus_wr && (bus_sel == RA_DATA);
    assign data_rd = bus_rd && (bus_sel == RA_DATA);
    assign flush   = ctrl_wr && bus_wdata[CTL_FLUSH];
    assign unused_bits = ^{bus_wdata[BW-1:DW], ser_din, data_rd};

    generate
        if (IS_PLAY) begin : g_play
            assign push_req = data_wr;
            assign push_din = bus_wdata[DW-1:0];
            assign pop_req  = ser_strobe;
        end else begin : g_cap
            assign push_req = ser_strobe;
            assign push_din = ser_din;
            assign pop_req  = data_rd;
        end
    endgenerate

    asfifo_capmap #(.TOTAL_WORDS(TOTAL_WORDS), .MAX_CH(MAX_CH), .CW(CW), .LW(LW)) u_capmap (
        .chans(cfg_chans), .cap_frames(cap_frames),
        .limit_words(limit_words), .cfg_bad(cfg_bad)
    );

    asfifo_fsm #(.LW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_bad(cfg_bad), .flush(flush),
        .push_req(push_req), .pop_req(pop_req), .words(words),
        .limit_words(limit_words), .push_ok(push_ok), .pop_ok(pop_ok),
        .ovf_ev(ovf_ev), .unf_ev(unf_ev), .state(state)
    );

    asfifo_store #(.DW(DW), .DEPTH(TOTAL_WORDS), .AW(AW), .LW(LW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push_ok),
        .pop(pop_ok), .din(push_din), .head(head), .words(words)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_en_q <= 1'b0;
            ovf_q     <= 1'b0;
            unf_q     <= 1'b0;
        end else begin
            if (ctrl_wr) half_en_q <= bus_wdata[CTL_HALF_EN];
            ovf_q <= (ovf_q && !(stat_wr && bus_wdata[ST_OVF])) || ovf_ev;
            unf_q <= (unf_q && !(stat_wr && bus_wdata[ST_UNF])) || unf_ev;
        end
    end

    always_comb begin
        frames   = cfg_bad ? '0 : LW'(words / LW'(cfg_chans));
        half_lvl = cap_frames >> 1;
        half_hit = IS_PLAY ? (frames <= half_lvl) : (frames >= half_lvl);
        irq_half = half_en_q && !cfg_bad && half_hit;
        cfg_err  = cfg_bad;
        ser_dout = (IS_PLAY && pop_ok) ? head : '0;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            RA_CTRL: bus_rdata[CTL_HALF_EN] = half_en_q;
            RA_STAT: begin
                bus_rdata[ST_LVL_LSB +: LW] = frames;
                bus_rdata[ST_OVF]           = ovf_q;
                bus_rdata[ST_UNF]           = unf_q;
            end
            RA_DATA: if (!IS_PLAY && pop_ok) bus_rdata[DW-1:0] = head;
            default: ;
        endcase
    end
endmodule

// File: rtl/asfifo_chk.sv
module asfifo_chk #(
    parameter int LW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_err,
    input logic          irq_half,
    input logic          flush,
    input logic          push_ok,
    input logic          pop_ok,
    input logic          ovf_ev,
    input logic          unf_ev,
    input logic          ovf_clr,
    input logic          unf_clr,
    input logic [LW-1:0] words,
    input logic          ovf_q,
    input logic          unf_q,
    input logic          half_en_q
);
    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> ovf_q);

    // R6
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !unf_clr) |=> unf_q);

    // R6
    unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_ev |=> unf_q);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (words == '0));

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_half |-> half_en_q);

    // R10
    badcfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !flush) |=> $stable(words));

    // R10
    badcfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !(push_ok || pop_ok));

    // R11
    both_xfer_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(words));
endmodule

bind audio_sample_fifo asfifo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_err(cfg_err), .irq_half(irq_half),
    .flush(flush), .push_ok(push_ok), .pop_ok(pop_ok),
    .ovf_ev(ovf_ev), .unf_ev(unf_ev),
    .ovf_clr(stat_wr && bus_wdata[4]), .unf_clr(stat_wr && bus_wdata[0]),
    .words(words), .ovf_q(ovf_q), .unf_q(unf_q), .half_en_q(half_en_q)
);

// File: tb/audio_sample_fifo_bench.sv
`timescale 1ns/1ps
module audio_sample_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg = 4'd2;
    logic [1:0]  sel = '0;
    logic        wr = 1'b0, rd = 1'b0, stb = 1'b0;
    logic [31:0] wd = '0;
    logic [23:0] din = '0;
    logic [31:0] rdata [2];
    logic [23:0] dout [2];
    logic        irq [2], err [2];

    int nchk = 0, nfail = 0;
    logic [23:0] mq [2][256];
    int mh [2], mn [2];
    bit movf [2], munf [2];
    bit mhalf = 1'b0;
    logic [31:0] s_rd [2];

    always #5 clk = ~clk;

    audio_sample_fifo #(.IS_PLAY(1'b1)) u_audio_sample_fifo (
        .clk(clk), .rst_n(rst_n), .cfg_chans(cfg), .cfg_err(err[0]),
        .bus_sel(sel), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wd),
        .bus_rdata(rdata[0]), .ser_strobe(stb), .ser_din(din),
        .ser_dout(dout[0]), .irq_half(irq[0]));

    audio_sample_fifo #(.IS_PLAY(1'b0)) u_audio_sample_fifo_cap (
        .clk(clk), .rst_n(rst_n), .cfg_chans(cfg), .cfg_err(err[1]),
        .bus_sel(sel), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wd),
        .bus_rdata(rdata[1]), .ser_strobe(stb), .ser_din(din),
        .ser_dout(dout[1]), .irq_half(irq[1]));

    function automatic int capf(int ch);
        case (ch)
            1: return 256;
            2: return 128;
            3, 4: return 64;
            5, 6, 7, 8: return 32;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle on both instances, check against the model, advance model
    task automatic drive(bit w, bit r, logic [1:0] s, logic [31:0] d, bit st, logic [23:0] di);
        @(negedge clk);
        wr = w; rd = r; sel = s; wd = d; stb = st; din = di;
        #2;
        for (int k = 0; k < 2; k++) begin
            int ch = int'(cfg);
            int cp = capf(ch);
            bit bad = (cp == 0);
            int lim = cp * ch;
            bit clr = w && s == 2'd0 && d[0];
            bit preq = (k == 0) ? (w && s == 2'd2) : st;
            bit qreq = (k == 0) ? st : (r && s == 2'd2);
            logic [23:0] pdat = (k == 0) ? d[23:0] : di;
            bit pok = qreq && !clr && !bad && mn[k] > 0;
            bit sok = preq && !clr && !bad && mn[k] < lim;
            logic [23:0] hd = pok ? mq[k][mh[k] % 256] : 24'h0;
            int fr = bad ? 0 : mn[k] / ch;
            bit hit = (k == 0) ? (fr <= cp / 2) : (fr >= cp / 2);
            logic [31:0] er = '0;
            string tag = "R12 address 3";
            case (s)
                2'd0: begin er[20] = mhalf; tag = "R12 control"; end
                2'd1: begin er[16:8] = 9'(fr); er[4] = movf[k]; er[0] = munf[k]; tag = "R3 R5 R6 R7 status"; end
                2'd2: begin if (k == 1) er[23:0] = hd; tag = "R4 data read"; end
                default: ;
            endcase
            chk(tag, rdata[k], er);
            chk("R4 serial out", {8'h0, dout[k]}, (k == 0) ? {8'h0, hd} : 32'h0);
            chk("R9 irq", {31'h0, irq[k]}, {31'h0, mhalf && !bad && hit});
            chk("R10 cfg_err", {31'h0, err[k]}, {31'h0, bad});
            s_rd[k] = rdata[k];
            // model update
            if (w && s == 2'd1) begin
                if (d[4]) movf[k] = 1'b0;
                if (d[0]) munf[k] = 1'b0;
            end
            if (preq && !clr && !sok) movf[k] = 1'b1;
            if (qreq && !clr && !pok) munf[k] = 1'b1;
            if (clr) begin
                mh[k] = 0; mn[k] = 0;
            end else begin
                if (pok) begin mh[k] = (mh[k] + 1) % 256; mn[k]--; end
                if (sok) begin mq[k][(mh[k] + mn[k]) % 256] = pdat; mn[k]++; end
            end
        end
        if (w && s == 2'd0) mhalf = d[20];
    endtask

    task automatic idle();
        drive(0, 0, 2'd0, 32'h0, 0, 24'h0);
    endtask

    task automatic read_stat();
        drive(0, 1, 2'd1, 32'h0, 0, 24'h0);
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            mh[k] = 0; mn[k] = 0; movf[k] = 0; munf[k] = 0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_stat();
        chk("R1 status play", s_rd[0], 32'h0);
        chk("R1 status cap", s_rd[1], 32'h0);
        drive(0, 1, 2'd0, 32'h0, 0, 24'h0);
        chk("R1 control", s_rd[0], 32'h0);

        // R12 enable readback
        drive(1, 0, 2'd0, 32'h0010_0000, 0, 24'h0);
        drive(0, 1, 2'd0, 32'h0, 0, 24'h0);
        chk("R12 control readback", s_rd[0], 32'h0010_0000);

        // R2 fill playback, 2 channels: 128 frames = 256 words
        for (int i = 0; i < 256; i++) drive(1, 0, 2'd2, {8'hA5, 16'(i * 257), 8'h00}, 0, 24'h0);
        read_stat();
        chk("R2 full level ch2", s_rd[0], 32'h0000_8000);
        drive(1, 0, 2'd2, 32'hFFFF_FFFF, 0, 24'h0);
        read_stat();
        chk("R5 overflow on full", s_rd[0], 32'h0000_8010);

        // R4 ordered pops, two samples
        drive(0, 0, 2'd0, 32'h0, 1, 24'h0);
        drive(0, 0, 2'd0, 32'h0, 1, 24'h0);
        // R11 push and pop together on partial FIFO: 254 words stays 127 frames
        drive(1, 0, 2'd2, 32'h0012_3400, 1, 24'h0);
        read_stat();
        chk("R11 partial push+pop", s_rd[0], 32'h0000_7F10);

        // R7 clear overflow
        drive(1, 0, 2'd1, 32'h0000_0010, 0, 24'h0);
        read_stat();
        chk("R7 clear ovf", s_rd[0], 32'h0000_7F00);
        drive(1, 0, 2'd2, 32'h0000_0100, 0, 24'h0);
        drive(1, 0, 2'd2, 32'h0000_0200, 0, 24'h0);
        // R11 at full: pop accepted, push dropped
        drive(1, 0, 2'd2, 32'h0000_0300, 1, 24'h0);
        read_stat();
        chk("R11 full push+pop", s_rd[0], 32'h0000_7F10);
        drive(1, 0, 2'd1, 32'h0, 0, 24'h0);
        read_stat();
        chk("R7 write zero keeps", s_rd[0], 32'h0000_7F10);

        // R8 flush together with a strobe
        drive(1, 0, 2'd0, 32'h0010_0001, 1, 24'h00ABCD);
        read_stat();
        chk("R8 flush play", s_rd[0], 32'h0000_0010);
        chk("R8 flush cap", s_rd[1], 32'h0);
        drive(0, 1, 2'd0, 32'h0, 0, 24'h0);
        chk("R8 flush bit self-clears", s_rd[0], 32'h0010_0000);

        // R6 pop on empty
        drive(0, 0, 2'd0, 32'h0, 1, 24'h0);
        read_stat();
        chk("R6 underflow", s_rd[0], 32'h0000_0011);

        // R10 illegal channel count
        drive(1, 0, 2'd1, 32'h0000_0011, 0, 24'h0);
        cfg = 4'd9;
        drive(1, 0, 2'd2, 32'h0000_0042, 0, 24'h0);
        read_stat();
        chk("R10 bad cfg push", s_rd[0], 32'h0000_0010);
        chk("R10 cfg_err out", {31'h0, err[0]}, 32'h1);

        // capture, one channel
        cfg = 4'd1;
        idle();
        drive(1, 0, 2'd0, 32'h0010_0001, 0, 24'h0);
        drive(1, 0, 2'd1, 32'h0000_0011, 0, 24'h0);
        for (int i = 0; i < 200; i++) drive(0, 0, 2'd0, 32'h0, 1, 24'(i * 40503 + 7));
        read_stat();
        chk("R3 capture level", s_rd[1], 32'h0000_C800);
        chk("R9 capture irq", {31'h0, irq[1]}, 32'h1);
        for (int i = 0; i < 3; i++) drive(0, 1, 2'd2, 32'h0, 0, 24'h0);
        for (int i = 0; i < 60; i++) drive(0, 0, 2'd0, 32'h0, 1, 24'(i + 11));
        read_stat();
        chk("R2 capture full ch1", s_rd[1], 32'h0001_0010);

        // random traffic across channel counts
        for (int p = 0; p < 5; p++) begin
            int chs [5] = '{1, 2, 3, 5, 8};
            cfg = 4'(chs[p]);
            idle();
            drive(1, 0, 2'd0, {11'h0, 1'($urandom), 19'h0, 1'b1}, 0, 24'h0);
            drive(1, 0, 2'd1, 32'h0000_0011, 0, 24'h0);
            for (int i = 0; i < 2500; i++) begin
                logic [1:0] rs = 2'($urandom);
                bit rw = ($urandom % 4) == 0;
                bit rr = ($urandom % 3) == 0;
                logic [31:0] rwd = $urandom;
                bit rst = ($urandom % 2) == 0;
                if (rs == 2'd0 && ($urandom % 32) != 0) rwd[0] = 1'b0;
                if (i < 800 && ($urandom % 2) == 0) begin rs = 2'd2; rw = 1'b1; rst = 1'b1; end
                drive(rw, rr, rs, rwd, rst, 24'($urandom));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule